// File: doc/BRIEF.md
# Multi-limit load zone encoder

This block turns a published 16-bit average duty measurement into a load zone and a set of stepping codes. Four programmable 12-bit thresholds, ordered from highest to lowest, split the duty range into five zones. The thresholds are compared against the upper 12 bits of the duty. Each time the producer pulses the update strobe, the block classifies the new duty, holds the zone until the next strobe, and registers the results on its outputs.

Two code outputs follow the zone. The 2-bit step code drives a clock generator up or down in four steps. The 3-bit zone code is looked up from a table of five programmable entries. A standby code replaces the table entry in two cases: an external active-low fault input when fault gating is enabled, or a timeout when duty has stayed too long inside a hysteresis band. Three flags report duty above the second-highest threshold, duty below the second-lowest threshold, and an out-of-range fault.

Top module: `load_zone_encoder`

## Requirements
- R1: The zone (0 below `lim0`, 1 between `lim0` and `lim1`, 2 between `lim1` and `lim2`, 3 between `lim2` and `lim3`, 4 above `lim3`, with `lim3 > lim2 > lim1 > lim0`) is re-evaluated only in a cycle where `duty_vld` is high. The outputs show the result after the clock edge that samples the strobe.
- R2: The step code is 2'b11 in zone 1, 2'b10 in zone 2 and 2'b01 in zone 3.
- R3: In zone 4 the step code is 2'b00, or 2'b01 when `hi_cmp_off` is set.
- R4: In zone 0 the step code is 2'b00, or 2'b11 when `lo_cmp_off` is set.
- R5: All compares are strict. A duty whose upper 12 bits equal any threshold keeps the previous zone.
- R6: Without an override, `zone_code` equals entry k of `code_tbl`, taken from bits [3k+2:3k], where k is the zone index.
- R7: While `flt_gate_en` is high and `flt_in_n` is low, `zone_code` equals `stby_code` one cycle later. With `flt_gate_en` low, `flt_in_n` has no effect.
- R8: Each threshold k has a band strictly between `lim_k` and `ret_k`. With `hys_en` and `tmo_en` both high, a run of consecutive strobes whose duty lies in any band drives `zone_code` to `stby_code` from the strobe at which the run length exceeds `tmo_lim`. A strobe outside every band, or a strobe with either enable low, ends the run and the override.
- R9: `over_hi` is 1 when the duty is above `lim2` and `under_lo` is 1 when it is below `lim1`. Both are refreshed at each strobe.
- R10: `fault_flag` is 1 when the duty is above `lim3` with `hi_cmp_off` low, or below `lim0` with `lo_cmp_off` low. Otherwise it is 0. It is refreshed at each strobe.
- R11: During reset, every output is 0.
- R12: The low 4 bits of `duty` do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty | input | 16 | Average duty value |
| duty_vld | input | 1 | New-average strobe |
| lim3 | input | 12 | Highest threshold |
| lim2 | input | 12 | Second threshold |
| lim1 | input | 12 | Third threshold |
| lim0 | input | 12 | Lowest threshold |
| ret3 | input | 12 | Return value paired with lim3 |
| ret2 | input | 12 | Return value paired with lim2 |
| ret1 | input | 12 | Return value paired with lim1 |
| ret0 | input | 12 | Return value paired with lim0 |
| hi_cmp_off | input | 1 | Disable the above-lim3 compare |
| lo_cmp_off | input | 1 | Disable the below-lim0 compare |
| code_tbl | input | 15 | Five 3-bit zone codes; zone k at [3k+2:3k] |
| stby_code | input | 3 | Standby override code |
| hys_en | input | 1 | Hysteresis mode enable |
| tmo_en | input | 1 | Band timeout enable |
| tmo_lim | input | 5 | Band timeout count |
| flt_in_n | input | 1 | External fault input, active low |
| flt_gate_en | input | 1 | Let the fault input force standby |
| step_code | output | 2 | Clock-step code |
| zone_code | output | 3 | Table or standby code |
| over_hi | output | 1 | Duty above lim2 |
| under_lo | output | 1 | Duty below lim1 |
| fault_flag | output | 1 | Duty outside the enabled outer limits |

## Verification
The hardest state to reach is the band timeout. It needs a long run of consecutive strobes that all land strictly inside a band, with both hysteresis enables set. At the default count that means 32 strobes in a row. The bench parks the duty inside a narrow band and fires strobes back to back. It checks that the code stays on the table entry through the last strobe at or below the count and switches to standby on the next one. It then shows that a single strobe outside the band restores the table code. The sweeps climb and descend over every 12-bit duty value, so each threshold equality is met from both sides.

// File: rtl/lze_pkg.sv
package lze_pkg;
  typedef enum logic [2:0] {
    Z_BELOW0 = 3'd0,
    Z_0_1    = 3'd1,
    Z_1_2    = 3'd2,
    Z_2_3    = 3'd3,
    Z_ABOVE3 = 3'd4
  } zone_e;

  // clock-step code for a zone, honouring the outer compare disables
  function automatic logic [1:0] step_of(zone_e z, logic hi_off, logic lo_off);
    case (z)
      Z_ABOVE3: step_of = hi_off ? 2'b01 : 2'b00;
      Z_2_3:    step_of = 2'b01;
      Z_1_2:    step_of = 2'b10;
      Z_0_1:    step_of = 2'b11;
      default:  step_of = lo_off ? 2'b11 : 2'b00;
    endcase
  endfunction

  // strict open interval test with either bound order
  function automatic logic inside_open(logic [11:0] v, logic [11:0] a, logic [11:0] b);
    logic [11:0] lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    inside_open = (v > lo) && (v < hi);
  endfunction
endpackage

// File: rtl/lze_classify.sv
module lze_classify
  import lze_pkg::*;
#(
  parameter int LIM_W = 12,
  parameter int NLIM  = 4
) (
  input  logic [LIM_W-1:0]      duty_hi,
  input  logic [NLIM*LIM_W-1:0] lim_flat,
  input  zone_e                 zone_prev,
  input  logic                  hi_off,
  input  logic                  lo_off,
  output zone_e                 zone_new,
  output logic                  ovr_hi_w,
  output logic                  und_lo_w,
  output logic                  fault_w
);
  logic [NLIM-1:0] gt, lt, eq;

  for (genvar k = 0; k < NLIM; k++) begin : g_cmp
    assign gt[k] = duty_hi >  lim_flat[k*LIM_W +: LIM_W];
    assign lt[k] = duty_hi <  lim_flat[k*LIM_W +: LIM_W];
    assign eq[k] = duty_hi == lim_flat[k*LIM_W +: LIM_W];
  end

  always_comb begin
    if (gt[NLIM-1])  zone_new = Z_ABOVE3;
    else if (lt[0])  zone_new = Z_BELOW0;
    else if (|eq)    zone_new = zone_prev;
    else             zone_new = zone_e'(3'($countones(gt)));
  end

  assign ovr_hi_w = gt[2];
  assign und_lo_w = lt[1];
  assign fault_w  = (gt[NLIM-1] && !hi_off) || (lt[0] && !lo_off);
endmodule

// File: rtl/lze_timeout.sv
module lze_timeout
  import lze_pkg::*;
#(
  parameter int LIM_W = 12,
  parameter int NLIM  = 4,
  parameter int TMO_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic                  arm,
  input  logic [LIM_W-1:0]      duty_hi,
  input  logic [NLIM*LIM_W-1:0] lim_flat,
  input  logic [NLIM*LIM_W-1:0] ret_flat,
  input  logic [TMO_W-1:0]      tmo_lim,
  output logic                  tmo_nxt,
  output logic                  tmo_q
);
  localparam int CNT_W = TMO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NLIM-1:0]  in_band;
  logic             band_hit;
  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_nxt;

  for (genvar k = 0; k < NLIM; k++) begin : g_band
    assign in_band[k] = inside_open(duty_hi, lim_flat[k*LIM_W +: LIM_W],
                                    ret_flat[k*LIM_W +: LIM_W]);
  end

  assign band_hit = arm && (|in_band);
  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    cnt_nxt = cnt_q;
    tmo_nxt = tmo_q;
    if (upd) begin
      cnt_nxt = band_hit ? cnt_inc : '0;
      tmo_nxt = band_hit && (cnt_inc > {1'b0, tmo_lim});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      tmo_q <= tmo_nxt;
    end
  end

  // R8
  tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> ($past(upd) && $past(arm)));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cnt_q));
endmodule

// File: rtl/load_zone_encoder.sv
module load_zone_encoder
  import lze_pkg::*;
#(
  parameter int DUTY_W = 16,
  parameter int LIM_W  = 12,
  parameter int CODE_W = 3,
  parameter int TMO_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DUTY_W-1:0]   duty,
  input  logic                duty_vld,
  input  logic [LIM_W-1:0]    lim3,
  input  logic [LIM_W-1:0]    lim2,
  input  logic [LIM_W-1:0]    lim1,
  input  logic [LIM_W-1:0]    lim0,
  input  logic [LIM_W-1:0]    ret3,
  input  logic [LIM_W-1:0]    ret2,
  input  logic [LIM_W-1:0]    ret1,
  input  logic [LIM_W-1:0]    ret0,
  input  logic                hi_cmp_off,
  input  logic                lo_cmp_off,
  input  logic [5*CODE_W-1:0] code_tbl,
  input  logic [CODE_W-1:0]   stby_code,
  input  logic                hys_en,
  input  logic                tmo_en,
  input  logic [TMO_W-1:0]    tmo_lim,
  input  logic                flt_in_n,
  input  logic                flt_gate_en,
  output logic [1:0]          step_code,
  output logic [CODE_W-1:0]   zone_code,
  output logic                over_hi,
  output logic                under_lo,
  output logic                fault_flag
);
  localparam int NLIM = 4;

  logic [LIM_W-1:0]      duty_hi;
  logic [NLIM*LIM_W-1:0] lim_flat, ret_flat;
  zone_e                 zone_q, zone_new, zone_nxt;
  logic                  ovr_hi_w, und_lo_w, fault_w;
  logic                  tmo_nxt, tmo_q, flt_ovr;

  assign duty_hi  = duty[DUTY_W-1 -: LIM_W];
  assign lim_flat = {lim3, lim2, lim1, lim0};
  assign ret_flat = {ret3, ret2, ret1, ret0};
  assign flt_ovr  = flt_gate_en && !flt_in_n;

  lze_classify #(.LIM_W(LIM_W), .NLIM(NLIM)) u_cls (
    .duty_hi  (duty_hi),
    .lim_flat (lim_flat),
    .zone_prev(zone_q),
    .hi_off   (hi_cmp_off),
    .lo_off   (lo_cmp_off),
    .zone_new (zone_new),
    .ovr_hi_w (ovr_hi_w),
    .und_lo_w (und_lo_w),
    .fault_w  (fault_w)
  );

  lze_timeout #(.LIM_W(LIM_W), .NLIM(NLIM), .TMO_W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (duty_vld),
    .arm     (hys_en && tmo_en),
    .duty_hi (duty_hi),
    .lim_flat(lim_flat),
    .ret_flat(ret_flat),
    .tmo_lim (tmo_lim),
    .tmo_nxt (tmo_nxt),
    .tmo_q   (tmo_q)
  );

  assign zone_nxt = duty_vld ? zone_new : zone_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zone_q     <= Z_BELOW0;
      step_code  <= 2'b00;
      zone_code  <= '0;
      over_hi    <= 1'b0;
      under_lo   <= 1'b0;
      fault_flag <= 1'b0;
    end else begin
      zone_q    <= zone_nxt;
      step_code <= step_of(zone_nxt, hi_cmp_off, lo_cmp_off);
      zone_code <= (tmo_nxt || flt_ovr) ? stby_code
                                        : code_tbl[CODE_W*int'(zone_nxt) +: CODE_W];
      if (duty_vld) begin
        over_hi    <= ovr_hi_w;
        under_lo   <= und_lo_w;
        fault_flag <= fault_w;
      end
    end
  end

  // R1
  zone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_vld |=> $stable(zone_q));

  // R2
  mid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_q inside {Z_0_1, Z_1_2, Z_2_3}) |-> (step_code != 2'b00));

  // R7
  flt_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_gate_en && !flt_in_n) |=> (zone_code == $past(stby_code)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_vld |=> $stable({over_hi, under_lo, fault_flag}));
endmodule

// File: tb/tb_load_zone_encoder.sv
module tb_load_zone_encoder;
  localparam int L3 = 12'hC00, L2 = 12'h800, L1 = 12'h400, L0 = 12'h200;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] duty = '0;
  logic        duty_vld = 1'b0;
  logic        hi_cmp_off = 1'b0, lo_cmp_off = 1'b0;
  logic [14:0] code_tbl;
  logic [2:0]  stby_code = 3'd6;
  logic        hys_en = 1'b0, tmo_en = 1'b0;
  logic [4:0]  tmo_lim = 5'd31;
  logic        flt_in_n = 1'b1, flt_gate_en = 1'b0;
  logic [11:0] ret3 = 12'hC00, ret2 = 12'h800, ret1 = 12'h440, ret0 = 12'h200;
  logic [1:0]  step_code;
  logic [2:0]  zone_code;
  logic        over_hi, under_lo, fault_flag;

  int total = 0, bad = 0, cyc = 0, mzone = 0;

  always #4 clk = ~clk;

  load_zone_encoder dut (
    .clk(clk), .rst_n(rst_n), .duty(duty), .duty_vld(duty_vld),
    .lim3(12'(L3)), .lim2(12'(L2)), .lim1(12'(L1)), .lim0(12'(L0)),
    .ret3(ret3), .ret2(ret2), .ret1(ret1), .ret0(ret0),
    .hi_cmp_off(hi_cmp_off), .lo_cmp_off(lo_cmp_off),
    .code_tbl(code_tbl), .stby_code(stby_code),
    .hys_en(hys_en), .tmo_en(tmo_en), .tmo_lim(tmo_lim),
    .flt_in_n(flt_in_n), .flt_gate_en(flt_gate_en),
    .step_code(step_code), .zone_code(zone_code),
    .over_hi(over_hi), .under_lo(under_lo), .fault_flag(fault_flag)
  );

  function automatic int tbl_entry(int z);
    return (z * 3 + 1) % 8;
  endfunction

  function automatic int exp_step(int z, logic hoff, logic loff);
    if (z == 4) return hoff ? 1 : 0;
    if (z == 0) return loff ? 3 : 0;
    return 4 - z;
  endfunction

  function automatic int next_zone(int d, int prev);
    if (d > L3) return 4;
    if (d < L0) return 0;
    if (d == L0 || d == L1 || d == L2 || d == L3) return prev;
    if (d > L2) return 3;
    if (d > L1) return 2;
    return 1;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe(int d12, int nib);
    @(negedge clk);
    duty = 16'((d12 << 4) | (nib & 15));
    duty_vld = 1'b1;
    @(negedge clk);
    duty_vld = 1'b0;
  endtask

  task automatic point(int d12);
    strobe(d12, d12 ^ 9);
    mzone = next_zone(d12, mzone);
    if (mzone == 0 || mzone == 4) begin
      if (mzone == 4) check("R3 step", step_code, exp_step(mzone, hi_cmp_off, lo_cmp_off));
      else            check("R4 step", step_code, exp_step(mzone, hi_cmp_off, lo_cmp_off));
    end else          check("R2/R5 step", step_code, exp_step(mzone, hi_cmp_off, lo_cmp_off));
    check("R6/R1 code", zone_code, tbl_entry(mzone));
    check("R9 over_hi", over_hi, int'(d12 > L2));
    check("R9 under_lo", under_lo, int'(d12 < L1));
    check("R10 fault", fault_flag,
          int'((d12 > L3 && !hi_cmp_off) || (d12 < L0 && !lo_cmp_off)));
  endtask

  initial begin
    for (int k = 0; k < 5; k++) code_tbl[3*k +: 3] = 3'(tbl_entry(k));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 step", step_code, 0);
    check("R11 code", zone_code, 0);
    check("R11 flags", {over_hi, under_lo, fault_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R9 R10: ascending and descending sweeps for every disable pair
    for (int cfg = 0; cfg < 4; cfg++) begin
      hi_cmp_off = cfg[1];
      lo_cmp_off = cfg[0];
      for (int d = 0; d < 4096; d++) point(d);
      for (int d = 4095; d >= 0; d--) point(d);
    end
    hi_cmp_off = 1'b0;
    lo_cmp_off = 1'b0;

    // R5: equality from above holds zone 2 at L1
    point(12'h500);
    point(L1);
    check("R5 hold-at-L1", zone_code, tbl_entry(2));

    // R12: low nibble makes no difference
    strobe(12'h600, 0);
    check("R12 nib0", {step_code, zone_code}, {2'b10, 3'(tbl_entry(2))});
    strobe(12'h600, 15);
    check("R12 nib15", {step_code, zone_code}, {2'b10, 3'(tbl_entry(2))});

    // R1: no strobe, duty moves, outputs stay
    @(negedge clk);
    duty = 16'hFFF0;
    repeat (3) @(negedge clk);
    check("R1 no-strobe step", step_code, 2);
    check("R1 no-strobe code", zone_code, tbl_entry(2));
    mzone = 2;

    // R7: fault override
    flt_in_n = 1'b0;
    @(negedge clk);
    check("R7 ungated", zone_code, tbl_entry(2));
    flt_gate_en = 1'b1;
    @(negedge clk);
    check("R7 standby", zone_code, 6);
    flt_in_n = 1'b1;
    @(negedge clk);
    check("R7 release", zone_code, tbl_entry(2));
    flt_gate_en = 1'b0;

    // R8: short timeout, band (0x400,0x440) around L1
    hys_en = 1'b1;
    tmo_en = 1'b1;
    tmo_lim = 5'd3;
    for (int i = 1; i <= 5; i++) begin
      strobe(12'h420, i);
      check("R8 tmo3", zone_code, (i > 3) ? 6 : tbl_entry(2));
    end
    strobe(12'h500, 0);
    check("R8 leave band", zone_code, tbl_entry(2));

    // R8: default count 31 needs 32 in-band strobes
    tmo_lim = 5'd31;
    for (int i = 1; i <= 33; i++) begin
      strobe(12'h410, i);
      if (i >= 30) check("R8 tmo31", zone_code, (i > 31) ? 6 : tbl_entry(2));
    end

    // R8: hysteresis off ends the override and blocks it
    hys_en = 1'b0;
    tmo_lim = 5'd1;
    for (int i = 1; i <= 4; i++) begin
      strobe(12'h420, i);
      check("R8 hys off", zone_code, tbl_entry(2));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule